// File: doc/BRIEF.md
# Edge-Selectable Timer Input Capture

This unit time-stamps events on an external pin. It brings the raw pin into the clock domain through a chain of flip-flops and watches it for one chosen transition. When that transition arrives, the unit copies the present value of a free-running 16-bit timer into a capture register. It also sets a sticky capture flag, and that flag drives an interrupt request line.

A single select input picks rising or falling transitions. The unit never looks at the timer's operating mode, so capture keeps working whether the timer is doing PWM, compare matching or plain counting. Software, or a neighbouring block, reads the captured value, then drops the flag with a one-cycle clear strobe. The interrupt line follows the flag only while the interrupt-enable input is high.

Top module: `tmr_capture_top`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `capValue` is 0, `capFlag` is 0 and `capIrq` is 0. The synchroniser stages also reset to 0.
- R2: With `edgeSel` = 1, a 0-to-1 change of `capPin` is a capture event. If the pin changes in the cycle in which the timer shows T, and the timer rises by one each cycle, `capValue` becomes T+2. This is the timer value at the third rising clock edge after the change: two synchroniser flops plus one detect stage.
- R3: With `edgeSel` = 0, a 1-to-0 change of `capPin` is a capture event, with the same latency as R2.
- R4: A transition of the polarity not selected by `edgeSel` leaves `capValue` and `capFlag` unchanged.
- R5: `capFlag` is set by a capture event and stays set until a cycle in which `flagClr` is 1. The clear takes effect at that clock edge.
- R6: When a capture event and `flagClr` fall on the same clock edge, the flag ends up set and the new value is captured.
- R7: `capIrq` equals `capFlag` AND `irqEn`, with no added delay.
- R8: `capValue` changes only on a capture event. Changes of `timerVal` at any other time have no effect on it.
- R9: A pin held at a constant level produces no further capture, however long it stays there.
- R10: A capture while the flag is already set overwrites `capValue` with the new timer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Raw, asynchronous capture pin |
| edgeSel | input | 1 | 1 = rising edge captures, 0 = falling edge captures |
| timerVal | input | 16 | Current count of the free-running timer |
| irqEn | input | 1 | Interrupt enable |
| flagClr | input | 1 | One-cycle strobe that clears the capture flag |
| capValue | output | 16 | Captured timer value |
| capFlag | output | 1 | Sticky capture flag |
| capIrq | output | 1 | Interrupt request |

## Verification
The assertions assume that `edgeSel` is steady across a detected edge. If it changes between two samples, one pin transition could count twice. The stimulus therefore changes `edgeSel` only while the pin has been still for several cycles, and it holds every pin level for at least two clocks. The bench drives all inputs just after a falling clock edge, so each one is stable at the rising edge that samples it. It keeps the pin low through reset, which matches the zero reset state of the synchroniser.

// File: rtl/cap_pkg.sv
package cap_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch timer, set flag
    logic clear;     // flag clear request
  } capStrobe_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capPin,
  input  logic                edgeSel,
  input  logic                flagClr,
  output cap_pkg::capStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   prevReg;
  logic                   riseSeen;
  logic                   fallSeen;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncReg[0] <= 1'b0;
          else        syncReg[0] <= capPin;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncReg[i] <= 1'b0;
          else        syncReg[i] <= syncReg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevReg <= 1'b0;
    else        prevReg <= syncReg[LAST];
  end

  always_comb begin
    riseSeen     = syncReg[LAST] && !prevReg;
    fallSeen     = !syncReg[LAST] && prevReg;
    strb.capture = edgeSel ? riseSeen : fallSeen;
    strb.clear   = flagClr;
  end

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture ##1 $stable(edgeSel) |-> !strb.capture);

  // R4
  no_edge_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(syncReg[LAST]) && $past(rst_n) && $stable(prevReg) && (syncReg[LAST] == prevReg) |-> !strb.capture);
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath #(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH-1:0]    timerVal,
  input  logic                irqEn,
  input  cap_pkg::capStrobe_t strb,
  output logic [WIDTH-1:0]    capValue,
  output logic                capFlag,
  output logic                capIrq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            capValue <= '0;
    else if (strb.capture) capValue <= timerVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            capFlag <= 1'b0;
    else if (strb.capture) capFlag <= 1'b1;
    else if (strb.clear)   capFlag <= 1'b0;
  end

  always_comb capIrq = capFlag && irqEn;

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> capValue == $past(timerVal));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(capValue));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> capFlag);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture && !strb.clear |=> $stable(capFlag));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capFlag |-> !capIrq);
endmodule

// File: rtl/tmr_capture_top.sv
module tmr_capture_top #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capPin,
  input  logic             edgeSel,
  input  logic [WIDTH-1:0] timerVal,
  input  logic             irqEn,
  input  logic             flagClr,
  output logic [WIDTH-1:0] capValue,
  output logic             capFlag,
  output logic             capIrq
);
  cap_pkg::capStrobe_t strb;

  cap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .capPin(capPin), .edgeSel(edgeSel),
    .flagClr(flagClr), .strb(strb)
  );

  cap_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .timerVal(timerVal), .irqEn(irqEn),
    .strb(strb), .capValue(capValue), .capFlag(capFlag), .capIrq(capIrq)
  );
endmodule

// File: tb/tmr_capture_top_bench.sv
module tmr_capture_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capPin = 1'b0;
  logic        edgeSel = 1'b1;
  logic [15:0] timerVal = 16'd0;
  logic        irqEn = 1'b0;
  logic        flagClr = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;
  logic        capIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_capture_top u_tmr_capture_top (
    .clk(clk), .rst_n(rst_n), .capPin(capPin), .edgeSel(edgeSel),
    .timerVal(timerVal), .irqEn(irqEn), .flagClr(flagClr),
    .capValue(capValue), .capFlag(capFlag), .capIrq(capIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: pin history queue plus model registers
  bit pinQ[$];
  int mVal = 0;
  bit mFlag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinQ = '{0, 0, 0};
      mVal = 0;
      mFlag = 0;
    end else begin
      bit older, newer, hit;
      newer = pinQ[pinQ.size()-2];
      older = pinQ[pinQ.size()-3];
      hit = edgeSel ? (newer && !older) : (!newer && older);
      if (hit) begin
        mVal = timerVal;
        mFlag = 1;
      end else if (flagClr) begin
        mFlag = 0;
      end
      pinQ.push_back(capPin);
      if (pinQ.size() > 5) void'(pinQ.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model capValue", capValue, mVal);
      chk("R5 model capFlag", capFlag, mFlag);
      chk("R7 model capIrq", capIrq, mFlag & irqEn);
    end
  end

  // advance one cycle; inputs change just after the falling edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 timerVal = timerVal + 16'd1;
    end
  endtask

  int t0;

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=finish");
          done = 1;
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    step(3);
    chk("R1 capValue in reset", capValue, 0);
    chk("R1 capFlag in reset", capFlag, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 capValue after reset", capValue, 0);
    chk("R1 capIrq after reset", capIrq, 0);

    // rising capture
    timerVal = 16'd100; edgeSel = 1'b1;
    capPin = 1'b1; t0 = timerVal;
    step(3);
    chk("R2 rising capture value", capValue, t0 + 2);
    chk("R2 rising capture flag", capFlag, 1);

    // hold high, no recapture
    step(8);
    chk("R9 steady level no recapture", capValue, t0 + 2);
    chk("R5 flag sticky", capFlag, 1);
    chk("R7 irq gated off", capIrq, 0);
    irqEn = 1'b1;
    #0 chk("R7 irq follows enable", capIrq, 1);
    flagClr = 1'b1; step(1); flagClr = 1'b0;
    chk("R5 flag cleared", capFlag, 0);
    chk("R7 irq low after clear", capIrq, 0);

    // falling edge ignored with rising selected
    capPin = 1'b0;
    step(6);
    chk("R4 unselected edge value", capValue, t0 + 2);
    chk("R4 unselected edge flag", capFlag, 0);
    chk("R8 timer moves, value held", capValue, t0 + 2);

    // falling selected
    edgeSel = 1'b0;
    step(3);
    capPin = 1'b1;
    step(6);
    chk("R4 rising ignored with falling selected", capFlag, 0);
    timerVal = 16'hFFF0;
    capPin = 1'b0; t0 = timerVal;
    step(3);
    chk("R3 falling capture value", capValue, (t0 + 2) & 16'hFFFF);
    chk("R3 falling capture flag", capFlag, 1);
    chk("R7 irq raised", capIrq, 1);

    // recapture while flag set
    step(2);
    capPin = 1'b1; step(3);
    capPin = 1'b0; t0 = timerVal;
    step(3);
    chk("R10 overwrite while flag set", capValue, (t0 + 2) & 16'hFFFF);

    // capture and clear on the same edge
    flagClr = 1'b1; step(1); flagClr = 1'b0;
    chk("R5 clear before race", capFlag, 0);
    capPin = 1'b1; step(4);
    capPin = 1'b0; t0 = timerVal;
    step(2);
    flagClr = 1'b1; step(1); flagClr = 1'b0;
    chk("R6 capture beats clear flag", capFlag, 1);
    chk("R6 capture beats clear value", capValue, (t0 + 2) & 16'hFFFF);

    irqEn = 1'b0;
    step(4);
    chk("R7 irq disabled", capIrq, 0);
    chk("R5 flag still set", capFlag, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule